// File: doc/BRIEF.md
# FIFO Watermark Interrupt Controller

This block turns the fill levels of a transmit FIFO and a receive FIFO into a single level-sensitive interrupt line. Every cycle it compares the two occupancy counts with two programmable watermarks and with the FIFO capacity. It records each condition that holds in a sticky status register, which software clears by writing ones.

An interrupt mask decides which status bits can raise the interrupt. Software never writes the mask directly. It has a set-only write port and a clear-only write port, and it can read the mask back. The FIFOs and the serial engine that fills and drains them sit outside this block. The block only sees their occupancy counts and the register write strobes.

The status, set, clear and mask words share one 7-bit layout:

| Bit | Meaning |
|-----|---------|
| 2 | TX level below the TX watermark |
| 3 | TX FIFO full |
| 4 | RX data at or above the RX watermark |

Bits 0, 1, 5 and 6 are always zero.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: Status bit 2 becomes 1 in the cycle after `tx_level` is lower than the TX watermark.
- R2: Status bit 3 becomes 1 in the cycle after `tx_level` equals the FIFO depth (default 63).
- R3: Status bit 4 becomes 1 in the cycle after `rx_level` is nonzero and at least the RX watermark. It stays 0 while `rx_level` is 0, even with a watermark of 0.
- R4: A set status bit stays set until a status-clear write has a one at its position. A zero in the written word leaves that bit unchanged. Bits 0, 1, 5 and 6 of the status and mask words always read 0.
- R5: If a status bit's condition is true in the same cycle as a clear write for that bit, the bit stays set. Once the condition is false, the clear takes effect.
- R6: A mask-set write sets the mask bits where `reg_wdata` has ones, one cycle later. Zero bits leave the mask unchanged. With no mask write, the mask holds its value.
- R7: A mask-clear write clears the mask bits where `reg_wdata` has ones. When a set write and a clear write hit the same bit in one cycle, the clear wins.
- R8: `irq` is 1 exactly when some status bit and the same mask bit are both 1.
- R9: After reset the TX watermark reads 1 and the RX watermark reads 32. A watermark write updates the readback one cycle later, and the new value is used for comparisons from then on.
- R10: During and right after reset, status and mask read 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_level | input | CNT_W | TX FIFO occupancy |
| rx_level | input | CNT_W | RX FIFO occupancy |
| wm_tx_we | input | 1 | Write strobe for the TX watermark |
| wm_rx_we | input | 1 | Write strobe for the RX watermark |
| wm_wdata | input | CNT_W | Watermark write value |
| stat_clr_we | input | 1 | Status write-one-to-clear strobe |
| msk_set_we | input | 1 | Mask-set write strobe |
| msk_clr_we | input | 1 | Mask-clear write strobe |
| reg_wdata | input | 7 | Data word for the status-clear, mask-set and mask-clear writes |
| stat_rd | output | 7 | Status register read value |
| mask_rd | output | 7 | Mask register read value |
| tx_wm_rd | output | CNT_W | TX watermark read value |
| rx_wm_rd | output | CNT_W | RX watermark read value |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check the following on every cycle:
- each fill condition leads to its status bit one cycle later;
- set bits stay set when no clear write occurs;
- unused bit positions stay zero;
- the set and clear writes move the mask, with the clear winning on a collision;
- `irq` matches the masked status.

Some behaviour only the bench scenarios can show:
- that a clear actually removes a bit once its condition has gone away;
- the reset values of the watermarks;
- that a new watermark changes when the comparisons fire.

The behavioural model in the bench, run against both directed and random write traffic, covers these.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int STAT_W      = 7;
  localparam int BIT_TX_LOW  = 2;
  localparam int BIT_TX_FULL = 3;
  localparam int BIT_RX_AVL  = 4;
  localparam logic [STAT_W-1:0] USED_BITS =
    STAT_W'((1 << BIT_TX_LOW) | (1 << BIT_TX_FULL) | (1 << BIT_RX_AVL));
endpackage

// File: rtl/fic_wm_regs.sv
module fic_wm_regs #(
  parameter int CNT_W  = 7,
  parameter int TX_RST = 1,
  parameter int RX_RST = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_we,
  input  logic             rx_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] tx_wm,
  output logic [CNT_W-1:0] rx_wm
);
  localparam logic [CNT_W-1:0] TX_INIT = CNT_W'(TX_RST);
  localparam logic [CNT_W-1:0] RX_INIT = CNT_W'(RX_RST);

  logic [CNT_W-1:0] tx_q, tx_d, rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    rx_d = rx_q;
    if (tx_we) tx_d = wdata;
    if (rx_we) rx_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= TX_INIT;
      rx_q <= RX_INIT;
    end else begin
      if (tx_we) tx_q <= tx_d;
      if (rx_we) rx_q <= rx_d;
    end
  end

  assign tx_wm = tx_q;
  assign rx_wm = rx_q;
endmodule

// File: rtl/fic_cond.sv
module fic_cond
  import fic_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int DEPTH = 63
) (
  input  logic [CNT_W-1:0]  tx_level,
  input  logic [CNT_W-1:0]  rx_level,
  input  logic [CNT_W-1:0]  tx_wm,
  input  logic [CNT_W-1:0]  rx_wm,
  output logic [STAT_W-1:0] cond
);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  always_comb begin
    cond = '0;
    cond[BIT_TX_LOW]  = (tx_level < tx_wm);
    cond[BIT_TX_FULL] = (tx_level == FULL_LVL);
    cond[BIT_RX_AVL]  = (rx_level != '0) && (rx_level >= rx_wm);
  end
endmodule

// File: rtl/fic_status.sv
module fic_status
  import fic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] cond,
  input  logic              clr_we,
  input  logic              set_msk_we,
  input  logic              clr_msk_we,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] stat,
  output logic [STAT_W-1:0] mask,
  output logic              irq
);
  logic [STAT_W-1:0] stat_q, stat_d, mask_q, mask_d;
  logic [STAT_W-1:0] clr_bits, set_bits, off_bits;

  assign clr_bits = clr_we     ? wdata : '0;
  assign set_bits = set_msk_we ? wdata : '0;
  assign off_bits = clr_msk_we ? wdata : '0;

  // a live condition overrides a clear in the same cycle
  always_comb begin
    stat_d = ((stat_q & ~clr_bits) | cond) & USED_BITS;
    mask_d = ((mask_q | set_bits) & ~off_bits) & USED_BITS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (set_msk_we || clr_msk_we) mask_q <= mask_d;
    end
  end

  assign stat = stat_q;
  assign mask = mask_q;
  assign irq  = |(stat_q & mask_q);
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fic_pkg::*;
#(
  parameter int CNT_W     = 7,
  parameter int DEPTH     = 63,
  parameter int TX_WM_RST = 1,
  parameter int RX_WM_RST = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  tx_level,
  input  logic [CNT_W-1:0]  rx_level,
  input  logic              wm_tx_we,
  input  logic              wm_rx_we,
  input  logic [CNT_W-1:0]  wm_wdata,
  input  logic              stat_clr_we,
  input  logic              msk_set_we,
  input  logic              msk_clr_we,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] stat_rd,
  output logic [STAT_W-1:0] mask_rd,
  output logic [CNT_W-1:0]  tx_wm_rd,
  output logic [CNT_W-1:0]  rx_wm_rd,
  output logic              irq
);
  logic [CNT_W-1:0]  tx_wm, rx_wm;
  logic [STAT_W-1:0] cond;

  fic_wm_regs #(.CNT_W(CNT_W), .TX_RST(TX_WM_RST), .RX_RST(RX_WM_RST)) u_wm (
    .clk(clk), .rst_n(rst_n), .tx_we(wm_tx_we), .rx_we(wm_rx_we),
    .wdata(wm_wdata), .tx_wm(tx_wm), .rx_wm(rx_wm));

  fic_cond #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_cond (
    .tx_level(tx_level), .rx_level(rx_level), .tx_wm(tx_wm), .rx_wm(rx_wm),
    .cond(cond));

  fic_status u_stat (
    .clk(clk), .rst_n(rst_n), .cond(cond), .clr_we(stat_clr_we),
    .set_msk_we(msk_set_we), .clr_msk_we(msk_clr_we), .wdata(reg_wdata),
    .stat(stat_rd), .mask(mask_rd), .irq(irq));

  assign tx_wm_rd = tx_wm;
  assign rx_wm_rd = rx_wm;
endmodule

// File: rtl/fifo_irq_ctrl_chk.sv
module fifo_irq_ctrl_chk
  import fic_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int DEPTH = 63
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  tx_level,
  input logic [CNT_W-1:0]  rx_level,
  input logic              stat_clr_we,
  input logic              msk_set_we,
  input logic              msk_clr_we,
  input logic [STAT_W-1:0] reg_wdata,
  input logic [STAT_W-1:0] stat_rd,
  input logic [STAT_W-1:0] mask_rd,
  input logic [CNT_W-1:0]  tx_wm_rd,
  input logic [CNT_W-1:0]  rx_wm_rd,
  input logic              irq
);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  p_txlow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level < tx_wm_rd) |=> stat_rd[BIT_TX_LOW]);

  p_txfull_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == FULL_LVL) |=> stat_rd[BIT_TX_FULL]);

  p_rxavl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level != '0 && rx_level >= rx_wm_rd) |=> stat_rd[BIT_RX_AVL]);

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr_we |=> ((stat_rd & $past(stat_rd)) == $past(stat_rd)));

  p_unused_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_rd | mask_rd) & ~USED_BITS) == '0);

  p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_set_we && !msk_clr_we) |=>
      ((mask_rd & $past(reg_wdata) & USED_BITS) == ($past(reg_wdata) & USED_BITS)));

  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!msk_set_we && !msk_clr_we) |=> $stable(mask_rd));

  p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msk_clr_we |=> ((mask_rd & $past(reg_wdata)) == '0));

  p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((stat_rd & mask_rd) != '0));
endmodule

bind fifo_irq_ctrl fifo_irq_ctrl_chk #(.CNT_W(CNT_W), .DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
  .stat_clr_we(stat_clr_we), .msk_set_we(msk_set_we), .msk_clr_we(msk_clr_we),
  .reg_wdata(reg_wdata), .stat_rd(stat_rd), .mask_rd(mask_rd),
  .tx_wm_rd(tx_wm_rd), .rx_wm_rd(rx_wm_rd), .irq(irq));

// File: tb/test_fifo_irq_ctrl.sv
module test_fifo_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 7;
  localparam int DEP = 63;

  logic clk, rst_n;
  logic [CW-1:0] tx_level, rx_level, wm_wdata;
  logic wm_tx_we, wm_rx_we, stat_clr_we, msk_set_we, msk_clr_we;
  logic [6:0] reg_wdata;
  logic [6:0] stat_rd, mask_rd;
  logic [CW-1:0] tx_wm_rd, rx_wm_rd;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit cmp_en = 0;

  fifo_irq_ctrl i_fifo_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
    .wm_tx_we(wm_tx_we), .wm_rx_we(wm_rx_we), .wm_wdata(wm_wdata),
    .stat_clr_we(stat_clr_we), .msk_set_we(msk_set_we), .msk_clr_we(msk_clr_we),
    .reg_wdata(reg_wdata), .stat_rd(stat_rd), .mask_rd(mask_rd),
    .tx_wm_rd(tx_wm_rd), .rx_wm_rd(rx_wm_rd), .irq(irq));

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_txwm, m_rxwm;
  bit m_st[7];
  bit m_mk[7];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_txwm = 1; m_rxwm = 32;
      foreach (m_st[i]) begin m_st[i] = 0; m_mk[i] = 0; end
    end else begin
      bit ev[7];
      foreach (ev[i]) ev[i] = 0;
      ev[2] = int'(tx_level) < m_txwm;
      ev[3] = int'(tx_level) == DEP;
      ev[4] = (int'(rx_level) > 0) && (int'(rx_level) >= m_rxwm);
      for (int i = 0; i < 7; i++) begin
        if (i < 2 || i > 4) begin m_st[i] = 0; m_mk[i] = 0; continue; end
        if (stat_clr_we && reg_wdata[i]) m_st[i] = 0;
        if (ev[i]) m_st[i] = 1;
        if (msk_set_we && reg_wdata[i]) m_mk[i] = 1;
        if (msk_clr_we && reg_wdata[i]) m_mk[i] = 0;
      end
      if (wm_tx_we) m_txwm = int'(wm_wdata);
      if (wm_rx_we) m_rxwm = int'(wm_wdata);
    end
  end

  function automatic int pack_st();
    int v = 0;
    for (int i = 0; i < 7; i++) if (m_st[i]) v += (1 << i);
    return v;
  endfunction
  function automatic int pack_mk();
    int v = 0;
    for (int i = 0; i < 7; i++) if (m_mk[i]) v += (1 << i);
    return v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    int ms = pack_st(), mm = pack_mk(), any_irq = 0;
    for (int i = 0; i < 7; i++) if (m_st[i] && m_mk[i]) any_irq = 1;
    chk("R1/R2/R3/R4/R5 status", int'(stat_rd), ms);
    chk("R6/R7 mask", int'(mask_rd), mm);
    chk("R8 irq", int'(irq), any_irq);
    chk("R9 tx watermark", int'(tx_wm_rd), m_txwm);
    chk("R9 rx watermark", int'(rx_wm_rd), m_rxwm);
  endtask

  always @(negedge clk) if (cmp_en) compare_all();

  task automatic idle();
    wm_tx_we = 0; wm_rx_we = 0; stat_clr_we = 0;
    msk_set_we = 0; msk_clr_we = 0;
  endtask

  task automatic cyc(); @(negedge clk); #1; idle(); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; idle(); reg_wdata = 0; wm_wdata = 0;
    tx_level = 7'd10; rx_level = 0;
    repeat (3) @(negedge clk);
    // R10 reset state, R9 reset watermarks
    chk("R10 reset status", int'(stat_rd), 0);
    chk("R10 reset mask", int'(mask_rd), 0);
    chk("R10 reset irq", int'(irq), 0);
    chk("R9 reset tx wm", int'(tx_wm_rd), 1);
    chk("R9 reset rx wm", int'(rx_wm_rd), 32);
    #1 rst_n = 1; cmp_en = 1;
    cyc();
    chk("R10 status after release", int'(stat_rd), 0);

    // R1: tx below watermark
    tx_level = 0; cyc();
    chk("R1 tx low set", int'(stat_rd[2]), 1);
    chk("R8 irq masked off", int'(irq), 0);
    // R6 enable tx-low, irq rises
    msk_set_we = 1; reg_wdata = 7'h04; cyc();
    chk("R6 mask set", int'(mask_rd), 7'h04);
    chk("R8 irq on", int'(irq), 1);
    // R5 clear while condition holds
    stat_clr_we = 1; reg_wdata = 7'h7F; cyc();
    chk("R5 event beats clear", int'(stat_rd[2]), 1);
    // R4 sticky after condition gone, then clear
    tx_level = 5; cyc();
    chk("R4 sticky", int'(stat_rd[2]), 1);
    stat_clr_we = 1; reg_wdata = 7'h08; cyc();
    chk("R4 zero bit no clear", int'(stat_rd[2]), 1);
    stat_clr_we = 1; reg_wdata = 7'h04; cyc();
    chk("R4 cleared", int'(stat_rd[2]), 0);
    chk("R8 irq off", int'(irq), 0);
    // R2 full
    tx_level = 7'(DEP); cyc();
    chk("R2 tx full", int'(stat_rd[3]), 1);
    tx_level = 5;
    // R3 rx below watermark then at watermark
    rx_level = 10; cyc();
    chk("R3 below rx wm", int'(stat_rd[4]), 0);
    rx_level = 32; cyc();
    chk("R3 at rx wm", int'(stat_rd[4]), 1);
    rx_level = 0;
    // R9 watermark write, R3 zero watermark with empty rx
    wm_rx_we = 1; wm_wdata = 0; cyc();
    chk("R9 rx wm write", int'(rx_wm_rd), 0);
    stat_clr_we = 1; reg_wdata = 7'h7F; cyc();
    cyc();
    chk("R3 empty rx no event", int'(stat_rd[4]), 0);
    // R9 tx watermark raise makes tx-low fire
    wm_tx_we = 1; wm_wdata = 8; cyc();
    cyc();
    chk("R9 new tx wm used", int'(stat_rd[2]), 1);
    // R7 set and clear together
    msk_set_we = 1; msk_clr_we = 1; reg_wdata = 7'h1C; cyc();
    chk("R7 clear wins", int'(mask_rd), 0);
    // R7 clear some
    msk_set_we = 1; reg_wdata = 7'h1C; cyc();
    msk_clr_we = 1; reg_wdata = 7'h08; cyc();
    chk("R7 partial clear", int'(mask_rd), 7'h14);
    // R4 unused bits
    msk_set_we = 1; reg_wdata = 7'h63; cyc();
    chk("R4 unused mask bits", int'(mask_rd), 7'h14);

    // random traffic, model compared every cycle
    for (int k = 0; k < 3000; k++) begin
      tx_level = 7'($urandom_range(0, DEP));
      if ($urandom_range(0, 3) == 0) tx_level = 7'(DEP);
      rx_level = 7'($urandom_range(0, DEP));
      if ($urandom_range(0, 3) == 0) rx_level = 0;
      reg_wdata = 7'($urandom);
      stat_clr_we = ($urandom_range(0, 2) == 0);
      msk_set_we  = ($urandom_range(0, 3) == 0);
      msk_clr_we  = ($urandom_range(0, 3) == 0);
      wm_wdata = 7'($urandom_range(0, DEP));
      wm_tx_we = ($urandom_range(0, 30) == 0);
      wm_rx_we = ($urandom_range(0, 30) == 0);
      cyc();
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule